// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block times one slot on an open-drain single-wire bus. Software writes a control word holding a low-pulse length and a sample delay, both in microsecond ticks. The engine pulls the line low for the pulse length and then releases it. After the delay it samples the line and raises a done flag with the sampled level beside it.

Every slot on this bus is built from that one pair of numbers: the long reset pulse with its presence sample, a read slot, a write-one slot, a write-zero slot, and a plain timed wait. Byte assembly and device command sequences are left to software. A prescaler divides the system clock into the microsecond tick. The pad appears as a pull-down enable output and a line level input.

Top module: `owb_slot_timer`

## Requirements
- R1: After reset, done reads 1, the sample bit reads 0 and the line is not driven.
- R2: The control word carries the low-pulse length in bits [19:10] and the sample delay in bits [9:2]. All other bits are ignored. A write accepted while done is 1 starts a slot, and done reads 0 from the next cycle.
- R3: With a nonzero pulse length P, the pull-down enable is 1 from the cycle after the accepting edge. It drops to 0 exactly P*CLK_DIV cycles after that edge.
- R4: Done returns to 1 exactly (P + D)*CLK_DIV cycles after the accepting edge, where D is the sample delay and a delay of 0 counts as 1.
- R5: The sample bit is the line level at the edge where done rises. It then holds, whatever the line does, until the next accepted write.
- R6: A pulse length of 0 never enables the pull-down, so the slot is only a timed wait of D ticks.
- R7: A control write while done is 0 is ignored. The running slot keeps its timing and result, and no second slot follows.
- R8: The tick fires once every CLK_DIV clocks, and its phase restarts at each accepted write, so slot length does not depend on when the write arrives.
- R9: The standard slots work at the line level. Reset is pulse 500 with delay 65, and a sample of 0 means a device is present. Read is 6/13, write-one is 6/110 and write-zero is 80/30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: pulse length and sample delay |
| stat_done | output | 1 | 1 when no slot is running |
| stat_bit | output | 1 | Line level sampled at the end of the last slot |
| line_pull | output | 1 | 1 enables the open-drain pull-down on the line |
| line_in | input | 1 | Line level seen at the pad |

## Verification
Each result has a due cycle counted from the edge that accepts the write. Done falls one cycle later. The pull-down is on from the next cycle and drops P*CLK_DIV cycles after the accepting edge. Done and the sample appear (P + max(D,1))*CLK_DIV cycles after that edge. The bench drives and samples on the falling edge. For every due point it checks the cycle just before the output changes and the cycle it changes, so a result that is one tick or one clock early or late is caught. The ignored-write and sample-hold checks look at the ports after the disturbing stimulus and before anything else can change them.

// File: rtl/owb_pkg.sv
package owb_pkg;

   // slot phases
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2
   } owb_phase_e;

   // default control word layout
   localparam int unsigned OWB_CTL_W     = 32;
   localparam int unsigned OWB_PULSE_LSB = 10;
   localparam int unsigned OWB_PULSE_W   = 10;
   localparam int unsigned OWB_DELAY_LSB = 2;
   localparam int unsigned OWB_DELAY_W   = 8;

endpackage

// File: rtl/owb_tick_gen.sv
module owb_tick_gen #(
   parameter int unsigned CLK_DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   localparam int unsigned PC_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   initial begin
      assert (CLK_DIV >= 1) else $error("owb_tick_gen: CLK_DIV must be at least 1");
   end

   generate
      if (CLK_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         logic [PC_W-1:0] pc_q;
         localparam logic [PC_W-1:0] PC_LAST = PC_W'(CLK_DIV - 1);

         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               pc_q <= '0;
            end else if (pc_q == PC_LAST) begin
               pc_q <= '0;
            end else begin
               pc_q <= pc_q + 1'b1;
            end
         end

         assign tick = (pc_q == PC_LAST);

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !restart) |=> !tick); // R8
         AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> !tick); // R8
      end
   endgenerate

endmodule

// File: rtl/owb_slot_ctrl.sv
module owb_slot_ctrl
   import owb_pkg::*;
#(
   parameter int unsigned PULSE_W = OWB_PULSE_W,
   parameter int unsigned DELAY_W = OWB_DELAY_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [PULSE_W-1:0] pulse_len,
   input  logic [DELAY_W-1:0] delay_len,
   input  logic               tick,
   input  logic               line_in,
   output logic               accept,
   output logic               line_pull,
   output logic               done,
   output logic               sample
);

   localparam int unsigned CNT_W = (PULSE_W > DELAY_W) ? PULSE_W : DELAY_W;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   initial begin
      assert (PULSE_W >= 1 && DELAY_W >= 1) else $error("owb_slot_ctrl: field widths must be nonzero");
   end

   owb_phase_e       ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] dly_q;
   logic [CNT_W-1:0] dly_eff;
   logic             done_q;
   logic             smp_q;

   // a zero delay still waits one tick so the sample never sees the own drive
   assign dly_eff = (delay_len == '0) ? CNT_ONE : CNT_W'(delay_len);
   assign accept  = wr && (ph_q == PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         dly_q  <= '0;
         done_q <= 1'b1;
         smp_q  <= 1'b0;
      end else if (accept) begin
         done_q <= 1'b0;
         dly_q  <= dly_eff;
         if (pulse_len != '0) begin
            ph_q  <= PH_LOW;
            cnt_q <= CNT_W'(pulse_len);
         end else begin
            ph_q  <= PH_WAIT;
            cnt_q <= dly_eff;
         end
      end else if (tick) begin
         unique case (ph_q)
            PH_LOW: begin
               if (cnt_q == CNT_ONE) begin
                  ph_q  <= PH_WAIT;
                  cnt_q <= dly_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_WAIT: begin
               if (cnt_q == CNT_ONE) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
                  smp_q  <= line_in;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               cnt_q <= cnt_q;
            end
         endcase
      end
   end

   assign line_pull = (ph_q == PH_LOW);
   assign done      = done_q;
   assign sample    = smp_q;

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !done); // R2
   AST_PULL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      line_pull |-> !done); // R3
   AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !line_pull); // R4
   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr) |=> $stable(sample)); // R5
   AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pulse_len == '0) |=> !line_pull); // R6
   AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !done) |=> $stable(dly_q)); // R7

endmodule

// File: rtl/owb_slot_timer.sv
module owb_slot_timer
   import owb_pkg::*;
#(
   parameter int unsigned CLK_DIV   = 100,
   parameter int unsigned CTL_W     = OWB_CTL_W,
   parameter int unsigned PULSE_LSB = OWB_PULSE_LSB,
   parameter int unsigned PULSE_W   = OWB_PULSE_W,
   parameter int unsigned DELAY_LSB = OWB_DELAY_LSB,
   parameter int unsigned DELAY_W   = OWB_DELAY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             stat_done,
   output logic             stat_bit,
   output logic             line_pull,
   input  logic             line_in
);

   initial begin
      assert (DELAY_LSB + DELAY_W <= PULSE_LSB) else $error("owb_slot_timer: delay field overlaps pulse field");
      assert (PULSE_LSB + PULSE_W <= CTL_W) else $error("owb_slot_timer: pulse field exceeds control word");
   end

   logic [PULSE_W-1:0] pulse_len;
   logic [DELAY_W-1:0] delay_len;
   logic               tick;
   logic               accept;
   logic               unused_ctl;

   assign pulse_len  = ctl_wdata[PULSE_LSB +: PULSE_W];
   assign delay_len  = ctl_wdata[DELAY_LSB +: DELAY_W];
   assign unused_ctl = ^ctl_wdata;

   owb_tick_gen #(
      .CLK_DIV (CLK_DIV)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .tick    (tick)
   );

   owb_slot_ctrl #(
      .PULSE_W (PULSE_W),
      .DELAY_W (DELAY_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctl_wr),
      .pulse_len (pulse_len),
      .delay_len (delay_len),
      .tick      (tick),
      .line_in   (line_in),
      .accept    (accept),
      .line_pull (line_pull),
      .done      (stat_done),
      .sample    (stat_bit)
   );

   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(!rst_n) && !rst_n |-> (stat_done && !stat_bit && !line_pull)); // R1

endmodule

// File: tb/tb_owb_slot_timer.sv
`timescale 1ns/1ps
module tb_owb_slot_timer;

   localparam int unsigned DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        stat_done;
   logic        stat_bit;
   logic        line_pull;
   logic        line_in;
   logic        dev_low = 1'b0;
   logic        pull_seen = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   assign line_in = !(line_pull || dev_low);

   owb_slot_timer #(.CLK_DIV(DIV)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .stat_done (stat_done),
      .stat_bit  (stat_bit),
      .line_pull (line_pull),
      .line_in   (line_in)
   );

   always @(negedge clk) if (line_pull) pull_seen <= 1'b1;

   task automatic check(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] word(input int p, input int d);
      return (32'(p) << 10) | (32'(d) << 2);
   endfunction

   // one accepted write; returns at the falling edge right after the accepting edge
   task automatic put_word(input logic [31:0] w);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = w;
      @(negedge clk);
      ctl_wr = 1'b0;
      ctl_wdata = '0;
   endtask

   task automatic run_slot(input int p, input int d, input logic low, input logic [31:0] extra,
                           input string tag);
      int rel, tot;
      rel = p * DIV;
      tot = (p + ((d == 0) ? 1 : d)) * DIV;
      dev_low = low;
      pull_seen = 1'b0;
      put_word(word(p, d) | extra);
      check(stat_done, 1'b0, {tag, " R2 done cleared after write"});
      if (p > 0) begin
         check(line_pull, 1'b1, {tag, " R3 pull on at start"});
         repeat (rel - 1) @(negedge clk);
         check(line_pull, 1'b1, {tag, " R3 pull on before release"});
         @(negedge clk);
         check(line_pull, 1'b0, {tag, " R3 released on time"});
      end else begin
         check(line_pull, 1'b0, {tag, " R6 no pull at start"});
      end
      repeat (tot - 1 - rel) @(negedge clk);
      check(stat_done, 1'b0, {tag, " R4 R8 done not early"});
      @(negedge clk);
      check(stat_done, 1'b1, {tag, " R4 R8 done on time"});
      check(stat_bit, !low, {tag, " R5 sampled level"});
      if (p == 0) check(pull_seen, 1'b0, {tag, " R6 line never driven"});
   endtask

   task automatic t_reset_state;
      check(stat_done, 1'b1, "R1 done after reset");
      check(stat_bit, 1'b0, "R1 sample after reset");
      check(line_pull, 1'b0, "R1 line released after reset");
   endtask

   task automatic t_standard_slots;
      run_slot(500, 65, 1'b1, '0, "R9 reset presence");
      run_slot(6, 13, 1'b0, '0, "R9 read one");
      run_slot(6, 13, 1'b1, '0, "R9 read zero");
      run_slot(6, 110, 1'b0, '0, "R9 write one");
      run_slot(80, 30, 1'b0, '0, "R9 write zero");
   endtask

   task automatic t_edges;
      run_slot(0, 100, 1'b0, '0, "R6 timed wait");
      run_slot(3, 0, 1'b0, '0, "R4 zero delay");
      run_slot(6, 13, 1'b1, 32'hFFF0_0003, "R2 other bits ignored");
   endtask

   task automatic t_busy_write;
      int tot;
      tot = (6 + 13) * DIV;
      dev_low = 1'b0;
      put_word(word(6, 13));
      repeat (5) @(negedge clk);
      put_word(word(80, 30));      // lands while busy
      repeat (tot - 1 - 7) @(negedge clk);
      check(stat_done, 1'b0, "R7 busy write keeps timing, not early");
      @(negedge clk);
      check(stat_done, 1'b1, "R7 busy write keeps timing, on time");
      check(stat_bit, 1'b1, "R7 result of original slot");
      repeat (10) @(negedge clk);
      check(line_pull, 1'b0, "R7 no second slot started");
      check(stat_done, 1'b1, "R7 still idle");
   endtask

   task automatic t_sample_hold;
      run_slot(6, 13, 1'b1, '0, "R5 hold setup");
      dev_low = 1'b0;
      repeat (20) @(negedge clk);
      check(stat_bit, 1'b0, "R5 sample holds after line change");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_standard_slots();
      t_edges();
      t_busy_write();
      t_sample_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule